// File: doc/BRIEF.md
# Accelerator Task Dispatch Controller

This block decides which of up to eight tasks a single-thread coprocessor runs next, and where in program memory that task begins. Each task owns a programmable 16-bit start vector, an enable bit and an 8-bit selector that picks one of 256 peripheral request lines. A task becomes pending when its selected line rises or when the host writes a one to its bit in the force register. The block then hands the start address of the highest-priority pending task to the fetch unit. Task 1 has the highest priority and task 8 the lowest.

A foreground task always runs until the coprocessor reports its end on `task_done`. The block then pulses that task's completion interrupt. On the same clock edge it launches the next pending task with no software involvement. A mode bit turns task 8 into a background loop. The background task runs whenever no foreground work is pending. A foreground task may interrupt it; when that happens the block saves the coprocessor's current program counter, and the background task later resumes from that saved address.

Register map, with word addresses on `reg_addr` and N = 8 tasks:
- 0..7: start vector of task k, at address k-1.
- 8..15: trigger selector of task k, at address 7+k, in bits [7:0].
- 16: enable mask, with bit k-1 for task k.
- 17: mode register; bit 0 set turns on background mode.
- 18: force register; writing a one to bit k-1 requests task k, and nothing is stored.

Top module: `task_dispatch_ctrl`

## Requirements
- R1: When task k is dispatched, `start_addr` equals the start vector of task k (register address k-1) and `active_task` equals k. Both outputs change one clock edge after the pending flag becomes visible.
- R2: While a foreground task is running, `active_task` does not change until `task_done` is sampled high. A newly pending task, including a higher-priority one, waits.
- R3: On the edge that samples `task_done` high while task k is active, `done_irq` bit k-1 goes high for exactly one cycle, and no other bit of `done_irq` is high.
- R4: On that same edge, if any foreground task is pending, the lowest-numbered pending task starts, and its pending bit clears. If no task is pending and background mode is off, `active_task` returns to 0.
- R5: Writing a one to bit k-1 of the force register (address 18) sets `pend_flags` bit k-1 on the write edge, but only if enable bit k-1 (address 16) is set. If the task is disabled, the write has no effect.
- R6: An enabled task becomes pending on a rising edge of the source line named by its selector (address 7+k). A line held high does not request the task again, and lines that are not selected have no effect.
- R7: A request that arrives while the task's pending bit is already set, and that bit is not being cleared on that edge, sets `ovf_flags` bit k-1. That bit stays set until reset or soft clear.
- R8: With mode bit 0 (address 17) set, task 8 starts from its vector whenever the block is idle, and it restarts from its vector after its own `task_done`. In this mode, force writes and peripheral triggers for task 8 are ignored.
- R9: When a foreground task starts while the background task is running and `task_done` is low, the block saves `cur_pc`. Once no foreground task is pending, task 8 resumes with `start_addr` equal to that saved value.
- R10: `rst` or `soft_clr` clears the pending flags, the overflow flags, the interrupt outputs and the running state, so that `active_task` reads 0 after that edge. `soft_clr` leaves the vectors, selectors, enables and mode intact.
- R11: `active_task` reads 0 when the coprocessor is idle and k while task k runs. `start_valid` is high for exactly the one cycle that follows each dispatch or resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_clr | input | 1 | Clears pending, overflow and running state |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 16 | Register write data |
| src_lines | input | 256 | Peripheral request lines |
| task_done | input | 1 | End-of-task strobe from the coprocessor |
| cur_pc | input | 16 | Coprocessor program counter, saved on background preemption |
| start_valid | output | 1 | One-cycle strobe: load `start_addr` into the program counter |
| start_addr | output | 16 | Start or resume address |
| active_task | output | 4 | Running task number, 0 when idle |
| done_irq | output | 8 | Per-task completion interrupt pulses |
| pend_flags | output | 8 | Pending flags |
| ovf_flags | output | 8 | Sticky overflow flags |

## Verification
The block is timed from the clock edge that samples a stimulus. A force write or a line rise shows up in `pend_flags` right after that edge. The resulting dispatch shows up in `start_valid`, `start_addr` and `active_task` one edge later. `task_done` produces the interrupt pulse and the follow-on dispatch together, right after the edge that samples it. The bench drives every input on the falling edge and reads the outputs on the next falling edge. A dispatch check therefore comes exactly one step after the pending check, and the interrupt check and the follow-on start check share the step after `task_done`. The random section also checks that a pulse is gone one step later.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

    // Kinds of register a host write can land on
    typedef enum logic [2:0] {
        RK_NONE,
        RK_VEC,
        RK_SEL,
        RK_ENA,
        RK_MODE,
        RK_FORCE
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [7:0] idx;
    } reg_dec_t;

    // Layout: N vectors, then N selectors, then enable, mode, force
    function automatic reg_dec_t reg_decode(int unsigned a, int unsigned n);
        reg_dec_t d;
        d.kind = RK_NONE;
        d.idx  = '0;
        if (a < n) begin
            d.kind = RK_VEC;
            d.idx  = 8'(a);
        end else if (a < 2 * n) begin
            d.kind = RK_SEL;
            d.idx  = 8'(a - n);
        end else if (a == 2 * n) begin
            d.kind = RK_ENA;
        end else if (a == 2 * n + 1) begin
            d.kind = RK_MODE;
        end else if (a == 2 * n + 2) begin
            d.kind = RK_FORCE;
        end
        return d;
    endfunction

endpackage

// File: rtl/tdc_regs.sv
module tdc_regs
    import tdc_pkg::*;
#(
    parameter int N_TASK = 8,
    parameter int VEC_W  = 16,
    parameter int SEL_W  = 8,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [VEC_W-1:0]  wdata,
    output logic [VEC_W-1:0]  vec [N_TASK],
    output logic [SEL_W-1:0]  sel [N_TASK],
    output logic [N_TASK-1:0] ena,
    output logic              bg_mode,
    output logic [N_TASK-1:0] force_mask
);

    reg_dec_t dec;
    assign dec = reg_decode(32'(addr), N_TASK);

    generate
        for (genvar i = 0; i < N_TASK; i++) begin : g_task_regs
            always_ff @(posedge clk) begin
                if (rst) begin
                    vec[i] <= '0;
                    sel[i] <= '0;
                end else if (we) begin
                    if (dec.kind == RK_VEC && dec.idx == 8'(i))
                        vec[i] <= wdata;
                    if (dec.kind == RK_SEL && dec.idx == 8'(i))
                        sel[i] <= wdata[SEL_W-1:0];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ena     <= '0;
            bg_mode <= 1'b0;
        end else if (we) begin
            if (dec.kind == RK_ENA)
                ena <= wdata[N_TASK-1:0];
            if (dec.kind == RK_MODE)
                bg_mode <= wdata[0];
        end
    end

    // Force bits act for the write cycle only
    assign force_mask = (we && dec.kind == RK_FORCE) ? wdata[N_TASK-1:0] : '0;

endmodule

// File: rtl/tdc_pending.sv
module tdc_pending #(
    parameter int N_TASK = 8,
    parameter int N_SRC  = 256,
    parameter int SEL_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_clr,
    input  logic [N_SRC-1:0]  src_lines,
    input  logic [SEL_W-1:0]  sel [N_TASK],
    input  logic [N_TASK-1:0] ena,
    input  logic [N_TASK-1:0] force_mask,
    input  logic              bg_mode,
    input  logic [N_TASK-1:0] clr_mask,
    output logic [N_TASK-1:0] pend,
    output logic [N_TASK-1:0] ovf
);

    logic [N_TASK-1:0] line, line_q, rise, blocked, req;

    generate
        for (genvar i = 0; i < N_TASK; i++) begin : g_edge
            assign line[i] = src_lines[sel[i]];
            assign rise[i] = line[i] & ~line_q[i];
            if (i == N_TASK - 1) begin : g_last
                assign blocked[i] = bg_mode;
            end else begin : g_fg
                assign blocked[i] = 1'b0;
            end
            assign req[i] = ena[i] & ~blocked[i] & (rise[i] | force_mask[i]);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) line_q <= '0;
        else     line_q <= line;
    end

    always_ff @(posedge clk) begin
        if (rst || soft_clr) begin
            pend <= '0;
            ovf  <= '0;
        end else begin
            pend <= (pend & ~clr_mask & ~blocked) | req;
            ovf  <= ovf | (req & pend & ~clr_mask);
        end
    end

endmodule

// File: rtl/tdc_sched.sv
module tdc_sched #(
    parameter int N_TASK = 8,
    parameter int VEC_W  = 16,
    parameter int ID_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_clr,
    input  logic [N_TASK-1:0] pend,
    input  logic [VEC_W-1:0]  vec [N_TASK],
    input  logic              bg_mode,
    input  logic              task_done,
    input  logic [VEC_W-1:0]  cur_pc,
    output logic [N_TASK-1:0] clr_mask,
    output logic              start_valid,
    output logic [VEC_W-1:0]  start_addr,
    output logic [ID_W-1:0]   active_task,
    output logic [N_TASK-1:0] done_irq,
    output logic              bg_run
);

    localparam int IDX_W = $clog2(N_TASK);
    localparam logic [ID_W-1:0] BG_ID = ID_W'(N_TASK);

    logic [IDX_W-1:0] pick_idx;
    logic             pick_hit;
    logic             ended, free_slot;
    logic             go_n, bg_n, save_now, drop_save;
    logic [ID_W-1:0]  id_n;
    logic [VEC_W-1:0] addr_n;
    logic [VEC_W-1:0] bg_save;
    logic             bg_hold;

    // Fixed priority: lowest index wins
    always_comb begin
        pick_hit = 1'b0;
        pick_idx = '0;
        for (int i = N_TASK - 1; i >= 0; i--) begin
            if (pend[i]) begin
                pick_hit = 1'b1;
                pick_idx = IDX_W'(i);
            end
        end
    end

    assign ended     = task_done && (active_task != '0);
    assign free_slot = (active_task == '0) || bg_run || ended;

    always_comb begin
        clr_mask  = '0;
        go_n      = 1'b0;
        id_n      = active_task;
        addr_n    = start_addr;
        bg_n      = bg_run;
        save_now  = 1'b0;
        drop_save = 1'b0;
        if (free_slot && pick_hit) begin
            go_n               = 1'b1;
            id_n               = ID_W'(pick_idx) + 1'b1;
            addr_n             = vec[pick_idx];
            clr_mask[pick_idx] = 1'b1;
            bg_n               = 1'b0;
            if (bg_run && !task_done) save_now  = 1'b1;
            else if (bg_run)          drop_save = 1'b1;
        end else if (free_slot && bg_mode && (!bg_run || ended)) begin
            go_n      = 1'b1;
            id_n      = BG_ID;
            bg_n      = 1'b1;
            addr_n    = (bg_hold && !bg_run) ? bg_save : vec[N_TASK-1];
            drop_save = 1'b1;
        end else if (ended) begin
            id_n = '0;
            bg_n = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || soft_clr) begin
            start_valid <= 1'b0;
            start_addr  <= '0;
            active_task <= '0;
            done_irq    <= '0;
            bg_run      <= 1'b0;
            bg_hold     <= 1'b0;
            bg_save     <= '0;
        end else begin
            start_valid <= go_n;
            start_addr  <= addr_n;
            active_task <= id_n;
            bg_run      <= bg_n;
            done_irq    <= ended ? (N_TASK'(1) << (active_task - 1'b1)) : '0;
            if (save_now) begin
                bg_hold <= 1'b1;
                bg_save <= cur_pc;
            end else if (drop_save) begin
                bg_hold <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/task_dispatch_ctrl.sv
module task_dispatch_ctrl #(
    parameter int N_TASK = 8,
    parameter int VEC_W  = 16,
    parameter int N_SRC  = 256,
    parameter int SEL_W  = $clog2(N_SRC),
    parameter int ID_W   = $clog2(N_TASK + 1),
    parameter int ADDR_W = $clog2(2 * N_TASK + 3)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_clr,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [VEC_W-1:0]  reg_wdata,
    input  logic [N_SRC-1:0]  src_lines,
    input  logic              task_done,
    input  logic [VEC_W-1:0]  cur_pc,
    output logic              start_valid,
    output logic [VEC_W-1:0]  start_addr,
    output logic [ID_W-1:0]   active_task,
    output logic [N_TASK-1:0] done_irq,
    output logic [N_TASK-1:0] pend_flags,
    output logic [N_TASK-1:0] ovf_flags
);

    logic [VEC_W-1:0]  vec [N_TASK];
    logic [SEL_W-1:0]  sel [N_TASK];
    logic [N_TASK-1:0] ena, force_mask, clr_mask;
    logic              bg_mode, bg_active;

    tdc_regs #(
        .N_TASK(N_TASK), .VEC_W(VEC_W), .SEL_W(SEL_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .vec(vec), .sel(sel), .ena(ena), .bg_mode(bg_mode), .force_mask(force_mask)
    );

    tdc_pending #(
        .N_TASK(N_TASK), .N_SRC(N_SRC), .SEL_W(SEL_W)
    ) u_pend (
        .clk(clk), .rst(rst), .soft_clr(soft_clr), .src_lines(src_lines),
        .sel(sel), .ena(ena), .force_mask(force_mask), .bg_mode(bg_mode),
        .clr_mask(clr_mask), .pend(pend_flags), .ovf(ovf_flags)
    );

    tdc_sched #(
        .N_TASK(N_TASK), .VEC_W(VEC_W), .ID_W(ID_W)
    ) u_sched (
        .clk(clk), .rst(rst), .soft_clr(soft_clr), .pend(pend_flags), .vec(vec),
        .bg_mode(bg_mode), .task_done(task_done), .cur_pc(cur_pc),
        .clr_mask(clr_mask), .start_valid(start_valid), .start_addr(start_addr),
        .active_task(active_task), .done_irq(done_irq), .bg_run(bg_active)
    );

endmodule

// File: rtl/task_dispatch_ctrl_chk.sv
module task_dispatch_ctrl_chk #(
    parameter int N_TASK = 8,
    parameter int ID_W   = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              soft_clr,
    input logic              task_done,
    input logic              start_valid,
    input logic [ID_W-1:0]   active_task,
    input logic [N_TASK-1:0] done_irq,
    input logic [N_TASK-1:0] pend_flags,
    input logic [N_TASK-1:0] ovf_flags,
    input logic              bg_mode,
    input logic              bg_active
);

    assert_no_preempt_R2: assert property (@(posedge clk) disable iff (rst)
        (active_task != '0 && !bg_active && !task_done && !soft_clr) |=> $stable(active_task));

    assert_irq_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(done_irq));

    assert_irq_follows_done_R3: assert property (@(posedge clk) disable iff (rst)
        (task_done && active_task != '0 && !soft_clr) |=> ($countones(done_irq) == 1));

    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (!soft_clr) |=> ((ovf_flags & $past(ovf_flags)) == $past(ovf_flags)));

    assert_bg_no_pend_R8: assert property (@(posedge clk) disable iff (rst)
        (bg_mode && $past(bg_mode)) |-> !pend_flags[N_TASK-1]);

    assert_soft_clear_R10: assert property (@(posedge clk) disable iff (rst)
        soft_clr |=> (pend_flags == '0 && ovf_flags == '0 && active_task == '0));

    assert_start_busy_R11: assert property (@(posedge clk) disable iff (rst)
        start_valid |-> (active_task != '0));

endmodule

bind task_dispatch_ctrl task_dispatch_ctrl_chk #(.N_TASK(N_TASK), .ID_W(ID_W)) u_chk (
    .clk(clk), .rst(rst), .soft_clr(soft_clr), .task_done(task_done),
    .start_valid(start_valid), .active_task(active_task), .done_irq(done_irq),
    .pend_flags(pend_flags), .ovf_flags(ovf_flags), .bg_mode(bg_mode),
    .bg_active(bg_active)
);

// File: tb/test_task_dispatch_ctrl.sv
`timescale 1ns/100ps
module test_task_dispatch_ctrl;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         soft_clr = 1'b0;
    logic         reg_we = 1'b0;
    logic [4:0]   reg_addr = '0;
    logic [15:0]  reg_wdata = '0;
    logic [255:0] src_lines = '0;
    logic         task_done = 1'b0;
    logic [15:0]  cur_pc = '0;
    logic         start_valid;
    logic [15:0]  start_addr;
    logic [3:0]   active_task;
    logic [7:0]   done_irq, pend_flags, ovf_flags;

    int checks = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    task_dispatch_ctrl i_task_dispatch_ctrl (
        .clk(clk), .rst(rst), .soft_clr(soft_clr), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .src_lines(src_lines),
        .task_done(task_done), .cur_pc(cur_pc), .start_valid(start_valid),
        .start_addr(start_addr), .active_task(active_task), .done_irq(done_irq),
        .pend_flags(pend_flags), .ovf_flags(ovf_flags)
    );

    function automatic logic [15:0] vec_of(int k);
        return 16'h1000 + 16'(k) * 16'h0234;
    endfunction

    function automatic int first_set(logic [7:0] m);
        for (int i = 0; i < 8; i++) if (m[i]) return i;
        return -1;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(logic [4:0] a, logic [15:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_we = 1'b0;
    endtask

    task automatic finish_task();
        task_done = 1'b1;
        step();
        task_done = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) step();
        rst = 1'b0;
        step();
        // R10 / R11: reset state
        chk("R10 reset active", active_task, 0);
        chk("R10 reset pend", pend_flags, 0);
        chk("R10 reset ovf", ovf_flags, 0);
        chk("R11 reset start_valid", start_valid, 0);
        chk("R3 reset irq", done_irq, 0);

        for (int k = 0; k < 8; k++) wr(5'(k), vec_of(k));
        wr(5'd16, 16'h00FF);

        // R5 force, R1 dispatch
        wr(5'd18, 16'h0004);
        chk("R5 force sets pending", pend_flags, 8'h04);
        step();
        chk("R1 active", active_task, 3);
        chk("R1 start addr", start_addr, vec_of(2));
        chk("R11 start strobe", start_valid, 1);
        chk("R4 pending cleared", pend_flags, 0);
        step();
        chk("R11 strobe single", start_valid, 0);

        // R2 no preemption
        wr(5'd18, 16'h0001);
        chk("R5 pending task1", pend_flags, 8'h01);
        repeat (3) step();
        chk("R2 still task3", active_task, 3);
        wr(5'd18, 16'h0001);
        chk("R7 overflow", ovf_flags, 8'h01);

        // R3 + R4
        finish_task();
        chk("R3 irq task3", done_irq, 8'h04);
        chk("R4 next task1", active_task, 1);
        chk("R4 next addr", start_addr, vec_of(0));
        chk("R4 strobe", start_valid, 1);
        step();
        chk("R3 irq pulse ends", done_irq, 0);
        finish_task();
        chk("R3 irq task1", done_irq, 8'h01);
        chk("R4 idle", active_task, 0);

        // R5 disabled task ignored
        wr(5'd16, 16'h00FE);
        wr(5'd18, 16'h0001);
        chk("R5 disabled ignored", pend_flags, 0);
        step();
        chk("R5 disabled no start", active_task, 0);
        wr(5'd16, 16'h00FF);

        // R6 peripheral trigger
        wr(5'd9, 16'd200);
        src_lines[200] = 1'b1;
        step();
        chk("R6 rise sets pending", pend_flags, 8'h02);
        step();
        chk("R6 dispatch task2", active_task, 2);
        repeat (2) step();
        chk("R6 held line no retrigger", pend_flags, 0);
        chk("R7 ovf sticky", ovf_flags, 8'h01);
        finish_task();
        chk("R3 irq task2", done_irq, 8'h02);
        src_lines[200] = 1'b0;
        step();
        src_lines[201] = 1'b1;
        step();
        chk("R6 other line ignored", pend_flags, 0);
        src_lines[201] = 1'b0;

        // R10 soft clear
        wr(5'd18, 16'h0030);
        chk("R5 two pending", pend_flags, 8'h30);
        step();
        chk("R4 priority task5", active_task, 5);
        soft_clr = 1'b1;
        step();
        soft_clr = 1'b0;
        chk("R10 soft active", active_task, 0);
        chk("R10 soft pend", pend_flags, 0);
        chk("R10 soft ovf", ovf_flags, 0);
        step();
        chk("R10 stays idle", active_task, 0);

        // R8 background
        wr(5'd7, 16'h8000);
        wr(5'd15, 16'd5);
        wr(5'd17, 16'h0001);
        step();
        chk("R8 bg start", active_task, 8);
        chk("R8 bg addr", start_addr, 16'h8000);
        cur_pc = 16'h8123;
        wr(5'd18, 16'h0080);
        chk("R8 force ignored", pend_flags, 0);
        src_lines[5] = 1'b1;
        step();
        src_lines[5] = 1'b0;
        chk("R8 trigger ignored", pend_flags, 0);
        chk("R8 bg keeps running", active_task, 8);

        // R9 preempt and resume
        wr(5'd18, 16'h0008);
        step();
        chk("R9 fg interrupts bg", active_task, 4);
        chk("R9 fg addr", start_addr, vec_of(3));
        cur_pc = 16'h0000;
        finish_task();
        chk("R3 irq task4", done_irq, 8'h08);
        chk("R9 resume bg", active_task, 8);
        chk("R9 resume addr", start_addr, 16'h8123);
        chk("R9 resume strobe", start_valid, 1);
        step();
        finish_task();
        chk("R8 bg irq", done_irq, 8'h80);
        chk("R8 bg restart addr", start_addr, 16'h8000);
        chk("R8 bg restart strobe", start_valid, 1);
        wr(5'd17, 16'h0000);
        finish_task();
        chk("R4 bg off idle", active_task, 0);
        wr(5'd7, vec_of(7));

        // Random priority sweeps (R4, R3, R1)
        for (int it = 0; it < 25; it++) begin
            logic [7:0] m;
            int cur, nxt;
            m = 8'($urandom_range(1, 255));
            wr(5'd18, {8'h00, m});
            chk("R5 random pending", pend_flags, m);
            step();
            cur = first_set(m);
            m[cur] = 1'b0;
            chk("R4 random first", active_task, cur + 1);
            chk("R1 random addr", start_addr, vec_of(cur));
            while (1) begin
                finish_task();
                chk("R3 random irq", done_irq, 32'(8'(1) << cur));
                nxt = first_set(m);
                if (nxt < 0) begin
                    chk("R4 random idle", active_task, 0);
                    break;
                end
                chk("R4 random next", active_task, nxt + 1);
                chk("R1 random next addr", start_addr, vec_of(nxt));
                m[nxt] = 1'b0;
                cur = nxt;
                step();
                chk("R3 random irq cleared", done_irq, 0);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule